// File: doc/BRIEF.md
# Interrupt Pin Redirection Controller

This block turns a small set of interrupt input pins into interrupt messages. Each pin owns one entry in a redirection table. The entry sets the vector, the destination, the delivery mode and the trigger mode that go into the message. It also holds the pin's polarity and a mask bit. Software reaches the table through an indirect window: it writes an index register to choose a word, then reads or writes the data register. A read-only version word describes the block. A separate write-only end-of-interrupt register accepts a vector number.

Edge-triggered pins produce one message for each rising edge of the polarity-corrected input. An edge that arrives while the pin is masked is thrown away. Level-triggered pins produce one message and then stay in service until software writes the entry's vector to the end-of-interrupt register. Messages leave one at a time on a valid/ready port. When several pins have work at the same time, the lowest pin index goes first. The pins are sampled on the block clock, so they must already be synchronous to it.

Top module: `irq_route_ctrl`

## Requirements
- R1: With index 0x01 selected, the data register reads 32 bits laid out as follows. Bits 7:0 hold the version parameter. Bits 23:16 hold NUM_PINS-1, the highest pin index, so the entry count is this field plus one. Bits 31:24 and 15:8 read as zero.
- R2: The register map has three offsets: 0x00 is the index register (read back in bits 7:0), 0x10 is the data window and 0x40 is the end-of-interrupt register. Index 0x10+2n selects entry n's low word and index 0x11+2n selects its high word. An index that selects nothing reads as zero.
- R3: The low word holds the vector in bits 7:0, the delivery mode in bits 10:8, polarity in bit 13, trigger mode in bit 15 (1 = level) and the mask in bit 16. All other low-word bits read as zero.
- R4: After reset, every entry's low word reads 0x00010000 (masked), and no message is presented.
- R5: For an edge entry, one rising edge of the corrected input gives exactly one message. That message carries the entry's vector, its destination, its delivery mode unchanged, and a level flag of 0.
- R6: With polarity 1 the pin is active-low. A falling pin edge counts as the assertion, and the rising release produces nothing.
- R7: An edge that arrives while the entry is masked is discarded. Clearing the mask later produces no message for it.
- R8: A level entry whose active input is held gives one message with the level flag at 1. It then gives no further message until the end-of-interrupt register is written with the entry's vector. A write naming a different vector has no effect.
- R9: One end-of-interrupt write releases every level entry programmed with that vector.
- R10: When several pins are waiting, messages are issued lowest pin index first, one per accepted handshake.
- R11: The high word carries the destination in bits 31:16 (ID in 31:24, extended ID in 23:16). The high word reads back as written, but a message uses a new destination only after the entry's low word has been written.
- R12: While a message is valid and not accepted, it stays valid and its fields do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the next cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Interrupt pins, synchronous to clk |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 16 | Message destination (ID, extended ID) |
| msg_mode | output | 3 | Delivery mode, passed through |
| msg_level | output | 1 | 1 when the source entry is level-triggered |

## Verification
The bench builds the block with six pins and version 0x15. With these values the version word's pin-index field reads 5, and the last table word (index 0x1B) can be reached. Six pins also lets one run hold two level entries on a shared vector, a simultaneous three-pin edge race, an active-low pin and the deferred-destination case all at once. Random trials then reprogram arbitrary pins with random vectors, destinations, modes and polarities.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [7:0] OFS_INDEX   = 8'h00;
  localparam logic [7:0] OFS_DATA    = 8'h10;
  localparam logic [7:0] OFS_EOI     = 8'h40;
  localparam logic [7:0] IDX_VERSION = 8'h01;
  localparam logic [7:0] IDX_TABLE   = 8'h10;

  localparam int LO_VEC  = 0;
  localparam int LO_MODE = 8;
  localparam int LO_POL  = 13;
  localparam int LO_TRIG = 15;
  localparam int LO_MASK = 16;
  localparam int HI_DEST = 16;

  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        lvl;
    logic        pol;
    logic [2:0]  mode;
    logic [7:0]  vec;
  } entry_t;

  function automatic logic [31:0] pack_low(entry_t e);
    logic [31:0] w;
    w = '0;
    w[LO_VEC +: 8]  = e.vec;
    w[LO_MODE +: 3] = e.mode;
    w[LO_POL]       = e.pol;
    w[LO_TRIG]      = e.lvl;
    w[LO_MASK]      = e.mask;
    return w;
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [7:0]                 bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output entry_t [NUM_PINS-1:0]      ent,
  output logic                       eoi_stb,
  output logic [7:0]                 eoi_vec
);

  localparam logic [7:0]  TOP_PIN  = 8'(NUM_PINS - 1);
  localparam logic [31:0] VER_WORD = {8'h00, TOP_PIN, 8'h00, VERSION};

  logic [7:0]                  idx_q;
  logic [NUM_PINS-1:0][15:0]   shadow_q;
  logic [31:0]                 rd_val;
  logic                        data_wr;
  logic                        unused_wbits;

  assign data_wr      = bus_wr && (bus_addr == OFS_DATA);
  assign unused_wbits = ^{bus_wdata[14], bus_wdata[12:11], bus_wdata[31:17]};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (bus_wr && (bus_addr == OFS_INDEX)) begin
      idx_q <= bus_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eoi_stb <= 1'b0;
      eoi_vec <= '0;
    end else begin
      eoi_stb <= bus_wr && (bus_addr == OFS_EOI);
      if (bus_wr && (bus_addr == OFS_EOI)) eoi_vec <= bus_wdata[7:0];
    end
  end

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_ent
    localparam logic [7:0] LO_IDX = IDX_TABLE + 8'(2 * n);
    localparam logic [7:0] HI_IDX = LO_IDX + 8'd1;
    entry_t     e_q;
    logic [15:0] sh_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        e_q      <= '0;
        e_q.mask <= 1'b1;
        sh_q     <= '0;
      end else if (data_wr) begin
        if (idx_q == HI_IDX) sh_q <= bus_wdata[HI_DEST +: 16];
        if (idx_q == LO_IDX) begin
          e_q.vec  <= bus_wdata[LO_VEC +: 8];
          e_q.mode <= bus_wdata[LO_MODE +: 3];
          e_q.pol  <= bus_wdata[LO_POL];
          e_q.lvl  <= bus_wdata[LO_TRIG];
          e_q.mask <= bus_wdata[LO_MASK];
          e_q.dest <= sh_q;
        end
      end
    end

    assign ent[n]      = e_q;
    assign shadow_q[n] = sh_q;
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == OFS_INDEX) begin
      rd_val = {24'h0, idx_q};
    end else if (bus_addr == OFS_DATA) begin
      if (idx_q == IDX_VERSION) rd_val = VER_WORD;
      for (int n = 0; n < NUM_PINS; n++) begin
        if (idx_q == IDX_TABLE + 8'(2 * n))        rd_val = pack_low(ent[n]);
        if (idx_q == IDX_TABLE + 8'(2 * n) + 8'd1) rd_val = {shadow_q[n], 16'h0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_val;
    end
  end

endmodule

// File: rtl/irq_route_pin.sv
module irq_route_pin (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic       pol,
  input  logic       lvl,
  input  logic       mask,
  input  logic [7:0] vec,
  input  logic       eoi_stb,
  input  logic [7:0] eoi_vec,
  input  logic       acc,
  output logic       req,
  output logic       pend_q,
  output logic       svc_q
);

  logic eff;
  logic prev_q;
  logic rise;

  assign eff  = pin ^ pol;
  assign rise = eff & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= eff;
  end

  // edge capture: a masked entry holds nothing pending
  always_ff @(posedge clk) begin
    if (rst || lvl || mask) pend_q <= 1'b0;
    else                    pend_q <= rise | (pend_q & ~acc);
  end

  // level in-service: acceptance sets it, matching EOI releases it
  always_ff @(posedge clk) begin
    if (rst || !lvl)                      svc_q <= 1'b0;
    else if (acc)                         svc_q <= 1'b1;
    else if (eoi_stb && eoi_vec == vec)   svc_q <= 1'b0;
  end

  assign req = lvl ? (eff & ~mask & ~svc_q) : pend_q;

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb #(
  parameter int NUM_PINS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        req,
  input  logic [NUM_PINS-1:0][7:0]   ent_vec,
  input  logic [NUM_PINS-1:0][15:0]  ent_dest,
  input  logic [NUM_PINS-1:0][2:0]   ent_mode,
  input  logic [NUM_PINS-1:0]        ent_lvl,
  input  logic                       msg_ready,
  output logic                       msg_valid,
  output logic [7:0]                 msg_vector,
  output logic [15:0]                msg_dest,
  output logic [2:0]                 msg_mode,
  output logic                       msg_level,
  output logic [NUM_PINS-1:0]        acc_oh
);

  localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic [SEL_W-1:0] pick;
  logic [SEL_W-1:0] sel_q;
  logic             any;

  always_comb begin
    pick = '0;
    any  = |req;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req[i]) pick = SEL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid  <= 1'b0;
      sel_q      <= '0;
      msg_vector <= '0;
      msg_dest   <= '0;
      msg_mode   <= '0;
      msg_level  <= 1'b0;
    end else if (msg_valid) begin
      if (msg_ready) msg_valid <= 1'b0;
    end else if (any) begin
      msg_valid  <= 1'b1;
      sel_q      <= pick;
      msg_vector <= ent_vec[pick];
      msg_dest   <= ent_dest[pick];
      msg_mode   <= ent_mode[pick];
      msg_level  <= ent_lvl[pick];
    end
  end

  always_comb begin
    acc_oh = '0;
    if (msg_valid && msg_ready) acc_oh[sel_q] = 1'b1;
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [15:0]         msg_dest,
  output logic [2:0]          msg_mode,
  output logic                msg_level
);

  entry_t [NUM_PINS-1:0]       ent;
  logic [NUM_PINS-1:0][7:0]    ent_vec;
  logic [NUM_PINS-1:0][15:0]   ent_dest;
  logic [NUM_PINS-1:0][2:0]    ent_mode;
  logic [NUM_PINS-1:0]         ent_lvl;
  logic [NUM_PINS-1:0]         ent_mask;
  logic [NUM_PINS-1:0]         req;
  logic [NUM_PINS-1:0]         pend_q;
  logic [NUM_PINS-1:0]         svc_q;
  logic [NUM_PINS-1:0]         acc_oh;
  logic                        eoi_stb;
  logic [7:0]                  eoi_vec;

  irq_route_regs #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent(ent), .eoi_stb(eoi_stb), .eoi_vec(eoi_vec)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign ent_vec[i]  = ent[i].vec;
    assign ent_dest[i] = ent[i].dest;
    assign ent_mode[i] = ent[i].mode;
    assign ent_lvl[i]  = ent[i].lvl;
    assign ent_mask[i] = ent[i].mask;

    irq_route_pin u_pin (
      .clk(clk), .rst(rst), .pin(pin_in[i]), .pol(ent[i].pol),
      .lvl(ent[i].lvl), .mask(ent[i].mask), .vec(ent[i].vec),
      .eoi_stb(eoi_stb), .eoi_vec(eoi_vec), .acc(acc_oh[i]),
      .req(req[i]), .pend_q(pend_q[i]), .svc_q(svc_q[i])
    );
  end

  irq_route_arb #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk(clk), .rst(rst), .req(req), .ent_vec(ent_vec),
    .ent_dest(ent_dest), .ent_mode(ent_mode), .ent_lvl(ent_lvl),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_mode(msg_mode), .msg_level(msg_level),
    .acc_oh(acc_oh)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      msg_valid,
  input logic                      msg_ready,
  input logic [7:0]                msg_vector,
  input logic [15:0]               msg_dest,
  input logic [2:0]                msg_mode,
  input logic                      msg_level,
  input logic                      eoi_stb,
  input logic [7:0]                eoi_vec,
  input logic [NUM_PINS-1:0][7:0]  ent_vec,
  input logic [NUM_PINS-1:0]       ent_lvl,
  input logic [NUM_PINS-1:0]       ent_mask,
  input logic [NUM_PINS-1:0]       pend_q,
  input logic [NUM_PINS-1:0]       svc_q,
  input logic [NUM_PINS-1:0]       acc_oh
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !msg_valid); // R4

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest)
                                   && $stable(msg_mode) && $stable(msg_level))); // R12

  AST_ONE_PER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |=> !msg_valid); // R10

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(acc_oh)); // R10

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_MASK_DROPS_EDGE: assert property (@(posedge clk) disable iff (rst)
      ent_mask[i] |=> !pend_q[i]); // R7

    AST_SVC_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      (acc_oh[i] && ent_lvl[i]) |=> svc_q[i]); // R8

    AST_EOI_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (eoi_stb && ent_lvl[i] && ent_vec[i] == eoi_vec && !acc_oh[i]) |=> !svc_q[i]); // R9
  end

endmodule

bind irq_route_ctrl irq_route_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_mode(msg_mode),
  .msg_level(msg_level), .eoi_stb(eoi_stb), .eoi_vec(eoi_vec),
  .ent_vec(ent_vec), .ent_lvl(ent_lvl), .ent_mask(ent_mask),
  .pend_q(pend_q), .svc_q(svc_q), .acc_oh(acc_oh)
);

// File: tb/sim_irq_route_ctrl.sv
`timescale 1ns/1ps
module sim_irq_route_ctrl;

  localparam int         NP  = 6;
  localparam logic [7:0] VER = 8'h15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pins = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_vector;
  logic [15:0] msg_dest;
  logic [2:0]  msg_mode;
  logic        msg_level;

  int checks = 0;
  int errs   = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  irq_route_ctrl #(.NUM_PINS(NP), .VERSION(VER)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_mode(msg_mode), .msg_level(msg_level)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errs = errs + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  function automatic logic [31:0] mk_low(logic [7:0] v, logic [2:0] m, logic p, logic l, logic k);
    return {15'b0, k, l, 1'b0, p, 2'b00, m, v};
  endfunction

  function automatic logic [31:0] ver_word();
    return {8'h00, 8'(NP - 1), 8'h00, VER};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_idx(input logic [7:0] idx, output logic [31:0] d);
    wr(8'h00, {24'h0, idx});
    rd(8'h10, d);
  endtask

  task automatic set_ent(input int n, input logic [31:0] lo, input logic [15:0] dest);
    wr(8'h00, 32'(8'h11 + 8'(2 * n)));
    wr(8'h10, {dest, 16'h0});
    wr(8'h00, 32'(8'h10 + 8'(2 * n)));
    wr(8'h10, lo);
  endtask

  task automatic set_low(input int n, input logic [31:0] lo);
    wr(8'h00, 32'(8'h10 + 8'(2 * n)));
    wr(8'h10, lo);
  endtask

  task automatic get_msg(output bit got, output logic [31:0] pk);
    got = 1'b0; pk = '0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        got = 1'b1;
        pk = {3'b0, 1'b1, msg_level, msg_mode, msg_vector, msg_dest};
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
      end
    end
  endtask

  task automatic expect_msg(input string tag, input logic [7:0] v, input logic [15:0] d,
                            input logic [2:0] m, input logic l);
    bit got;
    logic [31:0] pk, ex;
    get_msg(got, pk);
    ex = {3'b0, 1'b1, l, m, v, d};
    chk(got && pk == ex, tag, pk, ex);
  endtask

  task automatic expect_none(input string tag);
    bit seen;
    logic [31:0] pk;
    seen = 1'b0; pk = '0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (msg_valid && !seen) begin
        seen = 1'b1;
        pk = {3'b0, 1'b1, msg_level, msg_mode, msg_vector, msg_dest};
      end
    end
    chk(!seen, tag, pk, 32'h0);
  endtask

  task automatic pulse(input logic [NP-1:0] sel);
    @(negedge clk); pins = pins ^ sel;
    @(negedge clk); pins = pins ^ sel;
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  v0;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R4 reset state
    chk(msg_valid == 1'b0, "R4 no message after reset", {31'b0, msg_valid}, 32'h0);
    for (int n = 0; n < NP; n++) begin
      rd_idx(8'(8'h10 + 8'(2 * n)), d);
      chk(d == 32'h0001_0000, "R4 entry masked at reset", d, 32'h0001_0000);
    end

    // R1 version word
    rd_idx(8'h01, d);
    chk(d == ver_word(), "R1 version word", d, ver_word());

    // R2 index readback and unused index
    wr(8'h00, 32'h0000_0013);
    rd(8'h00, d);
    chk(d == 32'h13, "R2 index readback", d, 32'h13);
    rd_idx(8'h30, d);
    chk(d == 32'h0, "R2 unused index reads zero", d, 32'h0);

    // R3 / R11 field layout on the last entry
    set_ent(5, 32'hFFFF_FFFF, 16'hFFFF);
    rd_idx(8'h1A, d);
    chk(d == 32'h0001_A7FF, "R3 low word field layout", d, 32'h0001_A7FF);
    rd_idx(8'h1B, d);
    chk(d == 32'hFFFF_0000, "R11 high word readback", d, 32'hFFFF_0000);
    set_low(5, mk_low(8'h00, 3'd0, 1'b0, 1'b0, 1'b1));

    // R5 edge entry
    set_ent(2, mk_low(8'h42, 3'd2, 1'b0, 1'b0, 1'b0), 16'hA55A);
    pulse(6'b000100);
    expect_msg("R5 edge message fields", 8'h42, 16'hA55A, 3'd2, 1'b0);
    expect_none("R5 single edge single message");

    // R6 active-low
    pins[3] = 1'b1;
    set_ent(3, mk_low(8'h51, 3'd1, 1'b1, 1'b0, 1'b0), 16'h0301);
    expect_none("R6 idle active-low pin quiet");
    @(negedge clk); pins[3] = 1'b0;
    expect_msg("R6 falling edge fires", 8'h51, 16'h0301, 3'd1, 1'b0);
    @(negedge clk); pins[3] = 1'b1;
    expect_none("R6 release produces nothing");

    // R7 masked edge discarded
    set_low(2, mk_low(8'h42, 3'd2, 1'b0, 1'b0, 1'b1));
    pulse(6'b000100);
    set_low(2, mk_low(8'h42, 3'd2, 1'b0, 1'b0, 1'b0));
    expect_none("R7 masked edge not delivered after unmask");

    // R8 level entry and EOI
    pins[4] = 1'b1;
    set_ent(4, mk_low(8'h60, 3'd4, 1'b0, 1'b1, 1'b0), 16'h0404);
    expect_msg("R8 level message", 8'h60, 16'h0404, 3'd4, 1'b1);
    expect_none("R8 blocked while in service");
    wr(8'h40, 32'h61);
    expect_none("R8 EOI with other vector ignored");
    wr(8'h40, 32'h60);
    expect_msg("R8 redelivered after matching EOI", 8'h60, 16'h0404, 3'd4, 1'b1);
    @(negedge clk); pins[4] = 1'b0;
    wr(8'h40, 32'h60);
    expect_none("R8 inactive level after EOI quiet");

    // R9 shared vector
    wr(8'h00, 32'h11); wr(8'h10, 32'h00D0_0000);
    wr(8'h00, 32'h13); wr(8'h10, 32'h00D1_0000);
    @(negedge clk); pins[1:0] = 2'b11;
    set_low(0, mk_low(8'h70, 3'd0, 1'b0, 1'b1, 1'b0));
    set_low(1, mk_low(8'h70, 3'd0, 1'b0, 1'b1, 1'b0));
    expect_msg("R9 shared pin0 first", 8'h70, 16'h00D0, 3'd0, 1'b1);
    expect_msg("R9 shared pin1", 8'h70, 16'h00D1, 3'd0, 1'b1);
    expect_none("R9 both in service");
    wr(8'h40, 32'h70);
    expect_msg("R9 one EOI releases pin0", 8'h70, 16'h00D0, 3'd0, 1'b1);
    expect_msg("R9 one EOI releases pin1", 8'h70, 16'h00D1, 3'd0, 1'b1);
    @(negedge clk); pins[1:0] = 2'b00;
    wr(8'h40, 32'h70);
    expect_none("R9 released and idle");

    // R10 / R12 simultaneous edges
    set_ent(5, mk_low(8'h35, 3'd0, 1'b0, 1'b0, 1'b0), 16'h0505);
    pulse(6'b101100);
    for (int i = 0; i < 10 && !msg_valid; i++) @(negedge clk);
    v0 = msg_vector;
    repeat (3) @(negedge clk);
    chk(msg_valid && msg_vector == v0 && msg_dest == 16'hA55A, "R12 held while not ready",
        {15'b0, msg_valid, msg_dest}, {15'b0, 1'b1, 16'hA55A});
    expect_msg("R10 lowest first pin2", 8'h42, 16'hA55A, 3'd2, 1'b0);
    expect_msg("R10 next pin3", 8'h51, 16'h0301, 3'd1, 1'b0);
    expect_msg("R10 last pin5", 8'h35, 16'h0505, 3'd0, 1'b0);

    // R11 destination commit on low write
    wr(8'h00, 32'h1B); wr(8'h10, 32'hBEEF_0000);
    pulse(6'b100000);
    expect_msg("R11 old destination before low write", 8'h35, 16'h0505, 3'd0, 1'b0);
    set_low(5, mk_low(8'h35, 3'd0, 1'b0, 1'b0, 1'b0));
    pulse(6'b100000);
    expect_msg("R11 new destination after low write", 8'h35, 16'hBEEF, 3'd0, 1'b0);

    // R5 / R6 random edge trials
    for (int t = 0; t < 24; t++) begin
      int p;
      logic [7:0] rv;
      logic [15:0] rdst;
      logic [2:0] rm;
      logic rp;
      p    = int'($urandom % NP);
      rv   = 8'($urandom);
      rdst = 16'($urandom);
      rm   = 3'($urandom);
      rp   = 1'($urandom);
      set_low(p, mk_low(8'h00, 3'd0, 1'b0, 1'b0, 1'b1));
      @(negedge clk); pins[p] = rp;
      repeat (2) @(negedge clk);
      set_ent(p, mk_low(rv, rm, rp, 1'b0, 1'b0), rdst);
      @(negedge clk); pins[p] = ~rp;
      @(negedge clk); pins[p] = rp;
      expect_msg("R5 R6 random edge trial", rv, rdst, rm, 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule